// File: doc/BRIEF.md
# Tiled Tensor Address Generator

This block maps a logical element coordinate (row, column) of a 2D tensor onto its place in a tiled buffer. A tensor of higher rank is first flattened by the caller: the product of all outer dimensions becomes the row count and the innermost dimension becomes the column count, so a 1x4x6x8 tensor is presented as 24 rows of 8 columns. Tiles are always 32 columns wide. Their height is selectable, and tiles follow one another in row-major order across the tensor. Inside a tile the data is held as faces, which are sub-blocks stored one after another, and the elements inside each face follow a fixed order.

A start pulse in coordinate mode returns, one cycle later, the tile index, the logical face and the element offset inside the tile. A start pulse in streaming mode walks the entire tile that contains the given coordinate. It emits one element per clock in increasing storage-offset order. With each element it gives the row and column held at that offset, and it flags the final element. In transpose mode the four faces are stored column-major and the elements inside each face are stored column-major as well.

Top module: `tile_addr_gen`

## Requirements
- R1: While reset is held and after it is released, o_valid, o_last and o_err are 0 until a start is accepted.
- R2: A coordinate-mode start produces o_valid for exactly one cycle, in the cycle after the start. At that point o_tile = (row / H) * tiles_per_row + col / 32, where H is the tile height, and o_row and o_col echo the coordinate.
- R3: i_shape selects the tile height: 0 gives 32, 1 gives 16, 2 gives 4, 3 gives 2 and 4 gives 1. Codes 5 to 7 are rejected as errors.
- R4: The face index is 2*fr + fc. Here fr = 1 when the local row (row mod H) is 16 or more, and fc = 1 when the local column (col mod 32) is 16 or more. This gives 0 for top-left, 1 for top-right, 2 for bottom-left and 3 for bottom-right.
- R5: In normal mode the faces are stored in the slot order 0,1,2,3. The offset is slot*F + lr*16 + lc, where F is the number of elements in a face and lr, lc are the position inside the face.
- R6: In transpose mode the faces are stored in the slot order 0,2,1,3. The in-face term becomes lc*FH + lr, where FH is the face height.
- R7: For heights 32 and 16 a face is 16x16, with F = 256. For heights 4, 2 and 1 a tile holds only faces 0 and 1, each of height H, with F = 16*H. Faces 2 and 3 never appear for these heights.
- R8: A coordinate with row >= i_rows or col >= 32*i_tpr, or a rejected shape code, raises o_err for one cycle in the cycle after the start. No o_valid is produced in that case.
- R9: A streaming start produces 32*H consecutive o_valid cycles beginning one cycle after the cycle that follows the start. The offsets run 0, 1, 2 and so on. Each element reports the row and column it stores, and o_tile stays at the index of the tile. o_valid is low in the cycle after the final element.
- R10: o_last is high on the final element of a stream and at no other time.
- R11: A start that arrives while a stream is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | Start pulse |
| i_stream | input | 1 | 1 selects streaming mode, 0 selects coordinate mode |
| i_row | input | ROW_W | Row coordinate (flattened outer dimensions) |
| i_col | input | TPR_W+5 | Column coordinate |
| i_rows | input | ROW_W | Tensor row count |
| i_tpr | input | TPR_W | Tensor width in tiles |
| i_shape | input | 3 | Tile height code |
| i_transpose | input | 1 | Transposed face and element order |
| o_valid | output | 1 | Result strobe |
| o_last | output | 1 | Final element of a stream |
| o_err | output | 1 | Rejected request |
| o_tile | output | ROW_W+TPR_W | Tile index |
| o_face | output | 2 | Logical face index |
| o_off | output | 10 | Element offset inside the tile |
| o_row | output | ROW_W | Row of the reported element |
| o_col | output | TPR_W+5 | Column of the reported element |

## Verification
The case hardest to reach from the ports is a start pulse that lands in the middle of a running stream. The ports show no busy signal, so the bench times the pulse by counting emitted elements. It drives a conflicting coordinate-mode request at a chosen offset and then checks that every later element and the cycle after the last still match the original tile. Transposed short tiles are also easy to miss, so every shape code is streamed in both orders. These streams are mixed with random coordinates that sometimes fall out of range.

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int ROW_W = 16,
  parameter int TPR_W = 11,
  localparam int COL_W = TPR_W + 5,
  localparam int TILE_W = ROW_W + TPR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_start,
  input  logic              i_stream,
  input  logic [ROW_W-1:0]  i_row,
  input  logic [COL_W-1:0]  i_col,
  input  logic [ROW_W-1:0]  i_rows,
  input  logic [TPR_W-1:0]  i_tpr,
  input  logic [2:0]        i_shape,
  input  logic              i_transpose,
  output logic              o_valid,
  output logic              o_last,
  output logic              o_err,
  output logic [TILE_W-1:0] o_tile,
  output logic [1:0]        o_face,
  output logic [9:0]        o_off,
  output logic [ROW_W-1:0]  o_row,
  output logic [COL_W-1:0]  o_col
);

  logic [2:0] th_lg;
  logic       bad_shape;
  always_comb begin
    bad_shape = 1'b0;
    case (i_shape)
      3'd0: th_lg = 3'd5;
      3'd1: th_lg = 3'd4;
      3'd2: th_lg = 3'd2;
      3'd3: th_lg = 3'd1;
      3'd4: th_lg = 3'd0;
      default: begin th_lg = 3'd0; bad_shape = 1'b1; end
    endcase
  end

  wire [2:0]       fh_lg   = (th_lg > 3'd4) ? 3'd4 : th_lg;
  wire             four    = (th_lg == 3'd5);
  wire [4:0]       th_mask = 5'((6'd1 << th_lg) - 6'd1);
  wire [COL_W:0]   col_lim = {1'b0, i_tpr, 5'd0};
  wire             oob     = (i_row >= i_rows) || ({1'b0, i_col} >= col_lim);
  wire             bad     = bad_shape || oob;

  wire [4:0] lr = i_row[4:0] & th_mask;
  wire       fr = four & lr[4];
  wire       fc = i_col[4];
  wire [7:0] inner_f = i_transpose ? ((8'(i_col[3:0]) << fh_lg) | 8'(lr[3:0]))
                                   : {lr[3:0], i_col[3:0]};
  wire [1:0] slot_f = four ? (i_transpose ? {fc, fr} : {fr, fc}) : {1'b0, fc};
  wire [9:0] off_f = (10'(slot_f) << (4'(fh_lg) + 4'd4)) | 10'(inner_f);
  wire [TILE_W-1:0] tile_f = ((TILE_W'(i_row) >> th_lg) * TILE_W'(i_tpr))
                             + TILE_W'(i_col[COL_W-1:5]);

  logic              busy, q_tr, q_four;
  logic [9:0]        k;
  logic [2:0]        q_th_lg, q_fh_lg;
  logic [ROW_W-1:0]  base_r;
  logic [COL_W-1:0]  base_c;
  logic [TILE_W-1:0] q_tile;

  wire [9:0] last_k = 10'((11'd32 << q_th_lg) - 11'd1);
  wire [3:0] fe_lg  = 4'(q_fh_lg) + 4'd4;
  wire [1:0] slot_s = 2'(k >> fe_lg);
  wire [7:0] inner_s = 8'(k & 10'((11'd1 << fe_lg) - 11'd1));
  wire [3:0] fhm    = 4'((5'd1 << q_fh_lg) - 5'd1);
  wire [3:0] lcf_s  = q_tr ? 4'(inner_s >> q_fh_lg) : inner_s[3:0];
  wire [3:0] lrf_s  = q_tr ? (inner_s[3:0] & fhm) : inner_s[7:4];
  wire       fr_s   = q_four & (q_tr ? slot_s[0] : slot_s[1]);
  wire       fc_s   = (q_four & q_tr) ? slot_s[1] : slot_s[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; k <= '0; q_tr <= 1'b0; q_four <= 1'b0;
      q_th_lg <= '0; q_fh_lg <= '0; base_r <= '0; base_c <= '0; q_tile <= '0;
      o_valid <= 1'b0; o_last <= 1'b0; o_err <= 1'b0;
      o_tile <= '0; o_face <= '0; o_off <= '0; o_row <= '0; o_col <= '0;
    end else begin
      o_valid <= 1'b0;
      o_last  <= 1'b0;
      o_err   <= 1'b0;
      if (busy) begin
        o_valid <= 1'b1;
        o_tile  <= q_tile;
        o_face  <= {fr_s, fc_s};
        o_off   <= k;
        o_row   <= base_r | ROW_W'({fr_s, lrf_s});
        o_col   <= base_c | COL_W'({fc_s, lcf_s});
        k       <= k + 10'd1;
        if (k == last_k) begin
          busy   <= 1'b0;
          o_last <= 1'b1;
        end
      end else if (i_start) begin
        if (bad) begin
          o_err <= 1'b1;
        end else begin
          q_th_lg <= th_lg;
          q_fh_lg <= fh_lg;
          q_four  <= four;
          q_tr    <= i_transpose;
          if (i_stream) begin
            busy   <= 1'b1;
            k      <= '0;
            base_r <= i_row & ~ROW_W'(th_mask);
            base_c <= {i_col[COL_W-1:5], 5'd0};
            q_tile <= tile_f;
          end else begin
            o_valid <= 1'b1;
            o_tile  <= tile_f;
            o_face  <= {fr, fc};
            o_off   <= off_f;
            o_row   <= i_row;
            o_col   <= i_col;
          end
        end
      end
    end
  end

  a_r8_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(o_valid && o_err));
  a_r10_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    o_last |-> o_valid);
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    o_err |-> $past(i_start));
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && o_valid && !o_last) |=> (o_valid && o_off == $past(o_off) + 10'd1));
  a_r9_tile_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && o_valid) |=> $stable(o_tile));
  a_r7_short_faces: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !q_four) |-> !o_face[1]);
  a_r7_off_range: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_off <= last_k));

endmodule

// File: tb/tile_addr_gen_tb.sv
`timescale 1ns/1ps
module tile_addr_gen_tb;
  localparam int ROW_W = 16;
  localparam int TPR_W = 11;
  localparam int COL_W = TPR_W + 5;
  localparam int TILE_W = ROW_W + TPR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic i_start = 1'b0, i_stream = 1'b0, i_transpose = 1'b0;
  logic [ROW_W-1:0] i_row = '0, i_rows = '0;
  logic [COL_W-1:0] i_col = '0;
  logic [TPR_W-1:0] i_tpr = '0;
  logic [2:0] i_shape = '0;
  logic o_valid, o_last, o_err;
  logic [TILE_W-1:0] o_tile;
  logic [1:0] o_face;
  logic [9:0] o_off;
  logic [ROW_W-1:0] o_row;
  logic [COL_W-1:0] o_col;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tile_addr_gen #(.ROW_W(ROW_W), .TPR_W(TPR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_stream(i_stream),
    .i_row(i_row), .i_col(i_col), .i_rows(i_rows), .i_tpr(i_tpr),
    .i_shape(i_shape), .i_transpose(i_transpose),
    .o_valid(o_valid), .o_last(o_last), .o_err(o_err), .o_tile(o_tile),
    .o_face(o_face), .o_off(o_off), .o_row(o_row), .o_col(o_col));

  function automatic int ht(input int sh);
    case (sh) 0: return 32; 1: return 16; 2: return 4; 3: return 2; default: return 1; endcase
  endfunction

  function automatic int m_tile(input int r, input int c, input int tpr, input int sh);
    return (r / ht(sh)) * tpr + c / 32;
  endfunction

  function automatic int m_face(input int r, input int c, input int sh);
    int lr = r % ht(sh);
    return (lr / 16) * 2 + (c % 32) / 16;
  endfunction

  function automatic int m_off(input int r, input int c, input int sh, input bit tr);
    int h = ht(sh);
    int fh = (h < 16) ? h : 16;
    int lr = r % h, lc = c % 32;
    int fr = lr / 16, fc = lc / 16;
    int a = lr % 16, b = lc % 16;
    int inner = tr ? (b * fh + a) : (a * 16 + b);
    int slot;
    if (h == 32) slot = tr ? (fc * 2 + fr) : (fr * 2 + fc);
    else slot = fc;
    return slot * fh * 16 + inner;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic coord(input int r, input int c, input int rows, input int tpr,
                       input int sh, input bit tr, input string req);
    bit e = (sh > 4) || (r >= rows) || (c >= 32 * tpr);
    i_row = ROW_W'(r); i_col = COL_W'(c); i_rows = ROW_W'(rows); i_tpr = TPR_W'(tpr);
    i_shape = 3'(sh); i_transpose = tr; i_stream = 1'b0; i_start = 1'b1;
    @(negedge clk);
    i_start = 1'b0;
    if (e) begin
      chk(o_err && !o_valid, "R8", "err/valid", {o_err, o_valid}, 2);
    end else begin
      chk(o_valid && !o_err && !o_last, req, "strobe", {o_valid, o_err, o_last}, 4);
      chk(int'(o_tile) == m_tile(r, c, tpr, sh), "R2", "tile", int'(o_tile), m_tile(r, c, tpr, sh));
      chk(int'(o_face) == m_face(r, c, sh), "R4", "face", int'(o_face), m_face(r, c, sh));
      chk(int'(o_off) == m_off(r, c, sh, tr), req, "offset", int'(o_off), m_off(r, c, sh, tr));
      chk(int'(o_row) == r && int'(o_col) == c, "R2", "echo", int'(o_row), r);
    end
    @(negedge clk);
    chk(!o_valid && !o_err, "R2", "single strobe", {o_valid, o_err}, 0);
  endtask

  task automatic stream(input int r, input int c, input int rows, input int tpr,
                        input int sh, input bit tr, input int inj);
    int n = 32 * ht(sh);
    int et = m_tile(r, c, tpr, sh);
    i_row = ROW_W'(r); i_col = COL_W'(c); i_rows = ROW_W'(rows); i_tpr = TPR_W'(tpr);
    i_shape = 3'(sh); i_transpose = tr; i_stream = 1'b1; i_start = 1'b1;
    @(negedge clk);
    i_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k == inj) begin
        i_stream = 1'b0; i_row = '0; i_col = '0; i_shape = 3'd1; i_transpose = ~tr;
        i_start = 1'b1;
      end
      @(negedge clk);
      if (k == inj) begin
        i_start = 1'b0;
        i_shape = 3'(sh); i_transpose = tr;
      end
      chk(o_valid && !o_err, "R9", "stream valid", {o_valid, o_err}, 2);
      chk(int'(o_off) == k, inj >= 0 ? "R11" : "R9", "stream offset", int'(o_off), k);
      chk(int'(o_tile) == et, "R9", "stream tile", int'(o_tile), et);
      chk(o_last == (k == n - 1), "R10", "last", o_last, k == n - 1);
      chk(m_off(o_row, o_col, sh, tr) == k && int'(o_face) == m_face(o_row, o_col, sh),
          tr ? "R6" : "R5", "element at offset", m_off(o_row, o_col, sh, tr), k);
      chk(int'(o_row) / ht(sh) == r / ht(sh) && int'(o_col) / 32 == c / 32,
          "R9", "element in tile", int'(o_row), r);
      if (sh >= 2) chk(o_face < 2, "R7", "short face", int'(o_face), 1);
    end
    @(negedge clk);
    chk(!o_valid && !o_last, inj >= 0 ? "R11" : "R9", "end of stream", {o_valid, o_last}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd7);
    repeat (3) @(negedge clk);
    chk(!o_valid && !o_last && !o_err, "R1", "in reset", {o_valid, o_last, o_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!o_valid && !o_last && !o_err, "R1", "after reset", {o_valid, o_last, o_err}, 0);

    coord(0, 0, 64, 2, 0, 0, "R5");
    coord(0, 40, 64, 2, 0, 0, "R5");
    coord(40, 0, 64, 2, 0, 0, "R5");
    coord(63, 63, 64, 2, 0, 0, "R5");
    coord(0, 40, 64, 2, 0, 1, "R6");
    coord(20, 3, 64, 2, 0, 1, "R6");
    coord(23, 7, 24, 1, 0, 0, "R5");
    coord(5, 17, 16, 1, 1, 0, "R3");
    coord(6, 20, 16, 1, 2, 1, "R7");
    coord(3, 31, 8, 1, 3, 0, "R7");
    coord(9, 33, 16, 2, 4, 1, "R7");
    coord(64, 0, 64, 2, 0, 0, "R8");
    coord(0, 64, 64, 2, 0, 0, "R8");
    coord(0, 0, 64, 2, 5, 0, "R3");
    coord(0, 0, 64, 2, 7, 0, "R3");

    for (int i = 0; i < 400; i++) begin
      int tpr = 1 + $urandom % 8;
      int rows = 1 + $urandom % 300;
      int sh = ($urandom % 16 == 0) ? 5 + $urandom % 3 : $urandom % 5;
      int r = $urandom % (rows + 8);
      int c = $urandom % (32 * tpr + 16);
      bit tr = 1'($urandom);
      coord(r, c, rows, tpr, sh, tr, tr ? "R6" : "R5");
    end

    for (int sh = 0; sh < 5; sh++)
      for (int t = 0; t < 2; t++)
        stream(37 + 3 * sh, 45, 200, 3, sh, 1'(t), -1);
    stream(70, 10, 128, 2, 0, 1, 100);
    stream(5, 70, 16, 3, 2, 0, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule